// File: doc/BRIEF.md
# Parallel-to-Serial Display Link Transmitter

The block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane. It runs on a bit clock at seven times the pixel rate. That bit clock comes from outside the block and is phase-locked to the pixel clock. The pixel clock enters as a level that the block samples on the bit clock. A select input decides which pixel clock transition captures the word. On that transition the word is latched into a holding register. At the same time the word captured one pixel period earlier is parallel-loaded into four 7-bit shift registers, one per lane. Each shift register then sends its seven bits over the next seven bit-clock cycles.

The clock lane is a fifth shift register. It carries a fixed 7-slot pattern in every pixel period, so a receiver can recover both the pixel rate and the slot alignment. An active-low shutdown input works as an asynchronous clear of every register. While shutdown is low, all five outputs stay at zero and the pixel clock is ignored.

Top module: `dlink_ser_tx`

## Requirements
- R1: With `edge_sel_i` = 1, a low-to-high change of `pclk_i` (as sampled on `clk_i`) captures `data_i`.
- R2: With `edge_sel_i` = 0, a high-to-low change of `pclk_i` captures `data_i`.
- R3: Lane k (k = 0..3) carries `data_i[7k+6:7k]`. The bits are sent in slot order from bit 7k up to bit 7k+6, one bit per `clk_i` cycle.
- R4: A captured word starts on the lanes at the next capture. Its slot-0 bit appears on the lanes right after that capture's `clk_i` edge, so the pipeline latency is one pixel period.
- R5: Once loaded, `clk_lane_o` outputs the slot sequence 1,1,0,0,0,1,1 (slot 0 first) in every pixel period.
- R6: While `shdn_ni` is low, `lane_o` and `clk_lane_o` are 0 immediately, whatever `pclk_i` and `data_i` do.
- R7: Driving `shdn_ni` low clears every register. No word captured before the shutdown ever reaches the outputs after release.
- R8: After reset or shutdown release, all outputs stay 0 until a full word has been captured and then loaded by the following capture.
- R9: The inactive `pclk_i` transition captures nothing. Data that changes only around that transition never reaches a lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, 7x pixel rate, phase-locked to pclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shdn_ni | input | 1 | Active-low shutdown, asynchronous clear of all registers |
| edge_sel_i | input | 1 | Capture edge select: 1 rising, 0 falling |
| pclk_i | input | 1 | Pixel clock level |
| data_i | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Forwarded clock lane |

## Verification
A wrong slot alignment or wrong bit order shows up on the very next pixel period: the lane bits no longer match the expected slice in some slot, and the clock lane pattern moves against the data. A holding or valid flag that fails to clear in shutdown appears within two pixel periods after release, as stale data or an early clock pattern. A capture on the wrong edge loads the mid-period garbage word, which appears on every lane one pixel period later.

// File: rtl/dlink_pkg.sv
package dlink_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_RATIO = 7;

  // clock lane slot pattern: high on the first two and last two slots
  function automatic logic [31:0] clk_pattern(input int unsigned ratio);
    logic [31:0] p;
    p = '0;
    for (int unsigned s = 0; s < ratio; s++)
      p[s] = (s < 2) || (s + 2 >= ratio);
    return p;
  endfunction
endpackage

// File: rtl/dlink_edge_det.sv
module dlink_edge_det (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic pclk_i,
  input  logic sel_i,
  output logic cap_o
);
  logic pclk_q;
  logic primed_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      pclk_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      pclk_q   <= pclk_i;
      primed_q <= 1'b1;
    end
  end

  // primed_q blocks a false edge right after clear
  assign cap_o = primed_q && (pclk_i != pclk_q) && (pclk_i == sel_i);

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!clr_ni)
    cap_o |=> !cap_o); // R9
endmodule

// File: rtl/dlink_piso.sv
module dlink_piso #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic         ld_i,
  input  logic [W-1:0] par_i,
  output logic         ser_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)   sh_q <= '0;
    else if (ld_i) sh_q <= par_i;
    else           sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign ser_o = sh_q[0];

  AST_LSB_FIRST: assert property (@(posedge clk_i) disable iff (!clr_ni)
    ld_i |=> ser_o == $past(par_i[0])); // R3
endmodule

// File: rtl/dlink_ser_tx.sv
module dlink_ser_tx
  import dlink_pkg::*;
#(
  parameter int unsigned N_LANES = DEF_LANES,
  parameter int unsigned RATIO   = DEF_RATIO,
  localparam int unsigned WORD_W = N_LANES * RATIO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shdn_ni,
  input  logic               edge_sel_i,
  input  logic               pclk_i,
  input  logic [WORD_W-1:0]  data_i,
  output logic [N_LANES-1:0] lane_o,
  output logic               clk_lane_o
);
  localparam logic [31:0] PAT_FULL = clk_pattern(RATIO);
  localparam logic [RATIO-1:0] CLK_PAT = PAT_FULL[RATIO-1:0];

  logic              clr_n;
  logic              cap;
  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [RATIO-1:0]  clk_par;

  assign clr_n = rst_ni & shdn_ni;

  dlink_edge_det u_edge (
    .clk_i  (clk_i),
    .clr_ni (clr_n),
    .pclk_i (pclk_i),
    .sel_i  (edge_sel_i),
    .cap_o  (cap)
  );

  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (cap) begin
      hold_q     <= data_i;
      hold_vld_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    dlink_piso #(.W(RATIO)) u_piso (
      .clk_i  (clk_i),
      .clr_ni (clr_n),
      .ld_i   (cap),
      .par_i  (hold_q[g*RATIO +: RATIO]),
      .ser_o  (lane_o[g])
    );

    AST_LANE_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap |=> lane_o[g] == ($past(hold_q[g*RATIO]) && shdn_ni)); // R4
  end

  assign clk_par = hold_vld_q ? CLK_PAT : '0;

  dlink_piso #(.W(RATIO)) u_clk_piso (
    .clk_i  (clk_i),
    .clr_ni (clr_n),
    .ld_i   (cap),
    .par_i  (clk_par),
    .ser_o  (clk_lane_o)
  );

  AST_QUIET_SHDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |-> (lane_o == '0) && !clk_lane_o); // R6
  AST_CLK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap && hold_vld_q |=> clk_lane_o || !shdn_ni); // R5
  AST_NO_EARLY_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap && !hold_vld_q |=> !clk_lane_o); // R8
  AST_HOLD_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shdn_ni) |-> !hold_vld_q && (hold_q == '0)); // R7
endmodule

// File: tb/dlink_ser_tx_tb_top.sv
module dlink_ser_tx_tb_top;
  localparam int LN = 4;
  localparam int RT = 7;
  localparam int WW = LN * RT;
  localparam logic [RT-1:0] PAT = 7'b1100011;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shdn_n = 1'b1;
  logic          sel = 1'b1;
  logic          pclk = 1'b0;
  logic [WW-1:0] data = '0;
  logic [LN-1:0] lane;
  logic          clk_lane;

  int checks = 0;
  int errors = 0;

  logic [WW-1:0] m_hold, m_cur;
  bit m_hold_vld, m_cur_vld;

  dlink_ser_tx dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .shdn_ni    (shdn_n),
    .edge_sel_i (sel),
    .pclk_i     (pclk),
    .data_i     (data),
    .lane_o     (lane),
    .clk_lane_o (clk_lane)
  );

  always #10 clk = ~clk;

  function automatic logic [LN:0] exp_out(int slot, logic [WW-1:0] w, bit vld);
    logic [LN:0] e;
    e = '0;
    if (vld) begin
      for (int i = 0; i < LN; i++) e[i] = w[i*RT + slot];
      e[LN] = PAT[slot];
    end
    return e;
  endfunction

  task automatic check_out(logic [LN:0] e, string tag);
    checks++;
    if ({clk_lane, lane} !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, {clk_lane, lane}, e);
    end
  endtask

  task automatic model_clear();
    m_hold = '0; m_cur = '0; m_hold_vld = 0; m_cur_vld = 0;
  endtask

  task automatic period(logic [WW-1:0] w);
    string tag;
    for (int j = 0; j < RT; j++) begin
      @(negedge clk);
      if (!m_cur_vld) tag = "R7 R8";
      else tag = sel ? "R1 R3 R4 R5 R9" : "R2 R3 R4 R5 R9";
      check_out(exp_out((j == 0) ? RT - 1 : j - 1, m_cur, m_cur_vld), tag);
      if (j == 0) begin
        m_cur = m_hold; m_cur_vld = m_hold_vld;
        m_hold = w; m_hold_vld = 1;
        pclk = sel; data = w;
      end
      if (j == 3) begin
        pclk = ~sel;
        data = WW'($urandom()); // garbage around the inactive edge
      end
    end
  endtask

  task automatic shutdown(bit new_sel, int n);
    @(negedge clk);
    shdn_n = 1'b0;
    #1 check_out('0, "R6");
    model_clear();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pclk = 1'($urandom()); data = WW'($urandom());
      check_out('0, "R6");
    end
    sel = new_sel; pclk = ~new_sel;
    @(negedge clk);
    shdn_n = 1'b1;
    check_out('0, "R8");
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_clear();
    pclk = ~sel;
    repeat (3) @(negedge clk);
    check_out('0, "R8");
    rst_n = 1'b1;
    // directed corners, rising capture
    period(28'h0000000);
    period(28'hFFFFFFF);
    period(28'h0000001);
    period(28'h8000000);
    period(28'h0204081);
    period(28'h5555555);
    for (int k = 0; k < 40; k++) period(WW'($urandom()));
    // stale data must not survive shutdown
    period(28'hABCDEF1);
    shutdown(1'b0, 9);
    period(28'h1020408);
    period(28'hAAAAAAA);
    for (int k = 0; k < 40; k++) period(WW'($urandom()));
    shutdown(1'b1, 4);
    for (int k = 0; k < 20; k++) period(WW'($urandom()));
    period('0);
    period('0);
    finish_up();
  end
endmodule